// File: doc/BRIEF.md
# Temporal Execution Resource Partitioner

This block sits beside the select logic of a two-thread out-of-order issue stage. It decides which thread may use each shared issue port and functional unit in every cycle. The schedule is fixed: a rotation per resource that does not depend on which instructions the threads have ready. The block then masks the scheduler's per-entry ready bits so that an entry can only compete for a resource its own thread holds in that cycle. Because the allocation is decided before any thread does anything, one thread cannot see the other's use of a port or unit as extra latency.

Each temporally shared resource keeps a one-bit owner. A one-hot ring of N bits rotates every cycle, and the owner inverts when the ring's marker reaches its last position. A resource with N = 1 therefore alternates between the threads every cycle. A non-pipelined unit with worst-case latency L also closes its issue window for the last L-1 cycles of each slot. An operation started inside the window always finishes before the owner changes. A ready entry that meets the closed window waits for its thread's next slot. Resources that exist in duplicate are split between the threads at design time, and each copy has a constant owner. A global enable bypasses all masking.

The default parameter set has four resources. A single-cycle shared port rotates every cycle. A divider of latency 2 sits behind it with a slot of 3 cycles. Two ALU ports are split statically.

Top module: `exec_partitioner`

## Requirements
- R1: After reset every temporally shared resource reports thread 0 as owner, and the first cycle after reset is the first cycle of every resource's slot.
- R2: A shared resource with a slot length of 1 reports a different owner in every consecutive cycle.
- R3: A shared resource with slot length N keeps each owner for exactly N consecutive cycles and then hands over to the other thread, so the owner in cycle c after reset is (c / N) mod 2.
- R4: With partitioning enabled, an entry's gated ready bit can be 1 only if its thread bit (0 or 1) equals the current owner of the resource named by its select field, where the select value is the resource index.
- R5: For a non-pipelined resource with latency L and slot length N, entries that select it are blocked, even for the owner, in slot positions N-L+1 to N-1 (position = c mod N). A blocked entry passes again at position 0 of its thread's next slot. No operation granted by the block ever overlaps a change of owner.
- R6: A statically split resource reports its design-time owner in every cycle and never changes it.
- R7: With partitioning disabled, every gated ready bit equals its ready input, including for entries that select a non-pipelined unit inside its closed window.
- R8: An entry whose ready input is 0 always has gated ready 0.
- R9: Default configuration: resource 0 is shared with slot length 1 and latency 1. Resource 1 is shared with slot length 3 and latency 2. Resource 2 is statically owned by thread 0. Resource 3 is statically owned by thread 1. Bit r of the owner output belongs to resource r.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| partEn | input | 1 | Global partitioning enable; 0 bypasses all masking |
| entryReady | input | NUM_ENTRIES | Per-entry ready bits from wakeup |
| entryThread | input | NUM_ENTRIES | Per-entry thread bit |
| entryRes | input | NUM_ENTRIES x RES_W | Per-entry resource index |
| gatedReady | output | NUM_ENTRIES | Ready bits masked by ownership and issue window |
| ownerBits | output | NUM_RES | Current owner of each resource |

## Verification
The checker covers, on every cycle, the properties that relate state over time. Every gated grant must match the owner of its resource. Shared owners must change exactly at slot boundaries, and static owners must stay constant. With the enable low, or with ready low, the gated bits must follow the inputs. A counter started by each grant to a non-pipelined unit checks that the owner does not change while that operation is still running. The bench's scenarios show the rest: the exact phase of each schedule after reset, the position of the closed window inside a slot, the same thread's entry passing again in its next slot, and mixed traffic across all four resources against a cycle-count model.

// File: rtl/xpart_pkg.sv
`timescale 1ns/1ps
package xpart_pkg;
  // Upper bound on resources carried in the control-to-datapath strobe bundle.
  parameter int MAX_RES = 16;

  typedef enum logic { THREAD0 = 1'b0, THREAD1 = 1'b1 } threadId_e;

  typedef struct packed {
    logic [MAX_RES-1:0] owner;      // current owning thread per resource
    logic [MAX_RES-1:0] issueOpen;  // 1 while a new operation may start
  } schedStrobe_t;
endpackage

// File: rtl/xpart_schedule.sv
`timescale 1ns/1ps
module xpart_schedule
  import xpart_pkg::*;
#(
  parameter int NUM_RES = 4,
  parameter logic [NUM_RES-1:0][7:0] RES_PERIOD = {8'd1, 8'd1, 8'd3, 8'd1},
  parameter logic [NUM_RES-1:0][7:0] RES_LAT = {8'd1, 8'd1, 8'd2, 8'd1},
  parameter logic [NUM_RES-1:0] RES_SPATIAL = 4'b1100,
  parameter logic [NUM_RES-1:0] RES_FIXOWN = 4'b1000
) (
  input  logic         clk,
  input  logic         rst_n,
  output schedStrobe_t strobe
);

  logic [NUM_RES-1:0] ownerVec;
  logic [NUM_RES-1:0] openVec;

  for (genvar r = 0; r < NUM_RES; r++) begin : gRes
    if (RES_SPATIAL[r]) begin : gFixed
      // Duplicated resource: owner fixed at design time, never gapped.
      assign ownerVec[r] = RES_FIXOWN[r];
      assign openVec[r]  = 1'b1;
    end else begin : gTemporal
      localparam int P = int'(RES_PERIOD[r]);
      localparam int L = int'(RES_LAT[r]);
      logic [P-1:0] ring;
      logic         flip;
      logic         ownQ;

      if (P == 1) begin : gUnitSlot
        assign ring = 1'b1;
        assign flip = 1'b1;
      end else begin : gRing
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) ring <= P'(1);
          else        ring <= {ring[P-2:0], ring[P-1]};
        end
        assign flip = ring[P-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ownQ <= THREAD0;
        else if (flip) ownQ <= ~ownQ;
      end

      assign ownerVec[r] = ownQ;
      // Window open while the marker sits in positions 0 .. P-L.
      assign openVec[r]  = |ring[P-L:0];
    end
  end

  assign strobe.owner     = MAX_RES'(ownerVec);
  assign strobe.issueOpen = MAX_RES'(openVec);

endmodule

// File: rtl/xpart_gate.sv
`timescale 1ns/1ps
module xpart_gate
  import xpart_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int RES_W = 2
) (
  input  logic                                partEn,
  input  schedStrobe_t                        strobe,
  input  logic [NUM_ENTRIES-1:0]              entryReady,
  input  logic [NUM_ENTRIES-1:0]              entryThread,
  input  logic [NUM_ENTRIES-1:0][RES_W-1:0]   entryRes,
  output logic [NUM_ENTRIES-1:0]              gatedReady
);

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : gEntry
    logic [RES_W-1:0] sel;
    logic             ownMatch;
    logic             winOpen;
    assign sel      = entryRes[e];
    assign ownMatch = (entryThread[e] == strobe.owner[sel]);
    assign winOpen  = strobe.issueOpen[sel];
    assign gatedReady[e] = entryReady[e] & (~partEn | (ownMatch & winOpen));
  end

endmodule

// File: rtl/exec_partitioner.sv
`timescale 1ns/1ps
module exec_partitioner
  import xpart_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int NUM_RES = 4,
  parameter logic [NUM_RES-1:0][7:0] RES_PERIOD = {8'd1, 8'd1, 8'd3, 8'd1},
  parameter logic [NUM_RES-1:0][7:0] RES_LAT = {8'd1, 8'd1, 8'd2, 8'd1},
  parameter logic [NUM_RES-1:0] RES_SPATIAL = 4'b1100,
  parameter logic [NUM_RES-1:0] RES_FIXOWN = 4'b1000,
  localparam int RES_W = (NUM_RES > 1) ? $clog2(NUM_RES) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              partEn,
  input  logic [NUM_ENTRIES-1:0]            entryReady,
  input  logic [NUM_ENTRIES-1:0]            entryThread,
  input  logic [NUM_ENTRIES-1:0][RES_W-1:0] entryRes,
  output logic [NUM_ENTRIES-1:0]            gatedReady,
  output logic [NUM_RES-1:0]                ownerBits
);

  schedStrobe_t strobe;

  xpart_schedule #(
    .NUM_RES(NUM_RES),
    .RES_PERIOD(RES_PERIOD),
    .RES_LAT(RES_LAT),
    .RES_SPATIAL(RES_SPATIAL),
    .RES_FIXOWN(RES_FIXOWN)
  ) uSched (
    .clk(clk),
    .rst_n(rst_n),
    .strobe(strobe)
  );

  xpart_gate #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .RES_W(RES_W)
  ) uGate (
    .partEn(partEn),
    .strobe(strobe),
    .entryReady(entryReady),
    .entryThread(entryThread),
    .entryRes(entryRes),
    .gatedReady(gatedReady)
  );

  assign ownerBits = strobe.owner[NUM_RES-1:0];

endmodule

// File: rtl/exec_partitioner_chk.sv
`timescale 1ns/1ps
module exec_partitioner_chk #(
  parameter int NUM_ENTRIES = 8,
  parameter int NUM_RES = 4,
  parameter logic [NUM_RES-1:0][7:0] RES_PERIOD = {8'd1, 8'd1, 8'd3, 8'd1},
  parameter logic [NUM_RES-1:0][7:0] RES_LAT = {8'd1, 8'd1, 8'd2, 8'd1},
  parameter logic [NUM_RES-1:0] RES_SPATIAL = 4'b1100,
  parameter int RES_W = 2
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              partEn,
  input logic [NUM_ENTRIES-1:0]            entryReady,
  input logic [NUM_ENTRIES-1:0]            entryThread,
  input logic [NUM_ENTRIES-1:0][RES_W-1:0] entryRes,
  input logic [NUM_ENTRIES-1:0]            gatedReady,
  input logic [NUM_RES-1:0]                ownerBits
);

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : gEnt
    assert_owner_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (partEn && gatedReady[e]) |-> (entryThread[e] == ownerBits[entryRes[e]]));
    assert_idle_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !entryReady[e] |-> !gatedReady[e]);
  end

  assert_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !partEn |-> (gatedReady == entryReady));

  for (genvar r = 0; r < NUM_RES; r++) begin : gChkRes
    if (RES_SPATIAL[r]) begin : gFixed
      assert_static_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(ownerBits[r]));
    end else begin : gShared
      localparam int P = int'(RES_PERIOD[r]);
      localparam int L = int'(RES_LAT[r]);
      logic       prevOwn;
      logic [8:0] runLen;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prevOwn <= 1'b0;
          runLen  <= '0;
        end else begin
          prevOwn <= ownerBits[r];
          runLen  <= (ownerBits[r] != prevOwn) ? 9'd1 : runLen + 9'd1;
        end
      end

      assert_slot_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((ownerBits[r] != prevOwn) == (runLen == 9'(P))));

      if (P == 1) begin : gAlt
        assert_alternate_R2: assert property (@(posedge clk) disable iff (!rst_n)
          1'b1 |=> (ownerBits[r] != $past(ownerBits[r])));
      end

      if (L > 1) begin : gBusy
        logic       anyGrant;
        logic       grOwn;
        logic [7:0] remain;

        always_comb begin
          anyGrant = 1'b0;
          for (int e = 0; e < NUM_ENTRIES; e++)
            if (gatedReady[e] && (int'(entryRes[e]) == r)) anyGrant = 1'b1;
          anyGrant = anyGrant & partEn;
        end

        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            remain <= '0;
            grOwn  <= 1'b0;
          end else if (anyGrant) begin
            remain <= 8'(L - 1);
            grOwn  <= ownerBits[r];
          end else if (remain != 8'd0) begin
            remain <= remain - 8'd1;
          end
        end

        assert_gap_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
          (remain != 8'd0) |-> (ownerBits[r] == grOwn));
      end
    end
  end

endmodule

bind exec_partitioner exec_partitioner_chk #(
  .NUM_ENTRIES(NUM_ENTRIES),
  .NUM_RES(NUM_RES),
  .RES_PERIOD(RES_PERIOD),
  .RES_LAT(RES_LAT),
  .RES_SPATIAL(RES_SPATIAL),
  .RES_W(RES_W)
) uChk (
  .clk(clk),
  .rst_n(rst_n),
  .partEn(partEn),
  .entryReady(entryReady),
  .entryThread(entryThread),
  .entryRes(entryRes),
  .gatedReady(gatedReady),
  .ownerBits(ownerBits)
);

// File: tb/sim_exec_partitioner.sv
`timescale 1ns/1ps
module sim_exec_partitioner;
  localparam int NE = 8;
  localparam int NR = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              partEn = 1'b0;
  logic [NE-1:0]     entryReady = '0;
  logic [NE-1:0]     entryThread = '0;
  logic [NE-1:0][1:0] entryRes = '0;
  logic [NE-1:0]     gatedReady;
  logic [NR-1:0]     ownerBits;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  exec_partitioner u0 (
    .clk(clk), .rst_n(rst_n), .partEn(partEn),
    .entryReady(entryReady), .entryThread(entryThread), .entryRes(entryRes),
    .gatedReady(gatedReady), .ownerBits(ownerBits)
  );

  // Model of the default configuration (R9).
  function automatic logic expOwn(int r, int c);
    case (r)
      0: return logic'(c % 2);
      1: return logic'((c / 3) % 2);
      2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic expOpen(int r, int c);
    if (r == 1) return (c % 3) <= 1;
    return 1'b1;
  endfunction

  function automatic logic [NE-1:0] expGated(logic en, int c);
    logic [NE-1:0] v;
    for (int e = 0; e < NE; e++)
      v[e] = entryReady[e] & (!en | ((entryThread[e] == expOwn(int'(entryRes[e]), c))
                                     & expOpen(int'(entryRes[e]), c)));
    return v;
  endfunction

  function automatic logic [NR-1:0] expOwners(int c);
    logic [NR-1:0] v;
    for (int r = 0; r < NR; r++) v[r] = expOwn(r, c);
    return v;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s cyc=%0d actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic testReset();
    #1;
    check(ownerBits == 4'b1000, "R1 R9 owners during reset", 32'(ownerBits), 32'h8);
    step();
    rst_n = 1'b1;
    #1;
    check(cyc == 0 && ownerBits == expOwners(0), "R1 owners first cycle", 32'(ownerBits), 32'(expOwners(0)));
  endtask

  task automatic testSingleCycle();
    partEn = 1'b1;
    entryReady = '0; entryReady[1:0] = 2'b11;
    entryThread[0] = 1'b0; entryThread[1] = 1'b1;
    entryRes[0] = 2'd0; entryRes[1] = 2'd0;
    for (int i = 0; i < 6; i++) begin
      step(); #1;
      check(ownerBits[0] == expOwn(0, cyc), "R2 port owner", 32'(ownerBits[0]), 32'(expOwn(0, cyc)));
      check(gatedReady == expGated(1'b1, cyc), "R4 port gating", 32'(gatedReady), 32'(expGated(1'b1, cyc)));
    end
  endtask

  task automatic testPeriod();
    entryReady = '0;
    for (int i = 0; i < 9; i++) begin
      step(); #1;
      check(ownerBits[1] == logic'((cyc / 3) % 2), "R3 slot owner", 32'(ownerBits[1]), 32'((cyc / 3) % 2));
    end
  endtask

  task automatic testGap();
    int seen0 = 0;
    partEn = 1'b1;
    entryReady = '0; entryReady[1:0] = 2'b11;
    entryThread[0] = 1'b0; entryThread[1] = 1'b1;
    entryRes[0] = 2'd1; entryRes[1] = 2'd1;
    for (int i = 0; i < 12; i++) begin
      step(); #1;
      check(gatedReady == expGated(1'b1, cyc), "R5 divider window", 32'(gatedReady), 32'(expGated(1'b1, cyc)));
      if ((cyc % 3) == 2)
        check(gatedReady[1:0] == 2'b00, "R5 closed position", 32'(gatedReady[1:0]), 32'h0);
      if (gatedReady[0]) seen0++;
    end
    // Thread 0 owns 2 of 4 slots in 12 cycles, 2 open positions each.
    check(seen0 == 4, "R5 thread0 resumes next slot", 32'(seen0), 32'd4);
  endtask

  task automatic testSpatial();
    partEn = 1'b1;
    entryReady = '0; entryReady[3:0] = 4'hF;
    entryThread[3:0] = 4'b1010;
    entryRes[0] = 2'd2; entryRes[1] = 2'd2; entryRes[2] = 2'd3; entryRes[3] = 2'd3;
    for (int i = 0; i < 6; i++) begin
      step(); #1;
      check(ownerBits[3:2] == 2'b10, "R6 static owners", 32'(ownerBits[3:2]), 32'h2);
      check(gatedReady[3:0] == 4'b1001, "R6 static gating", 32'(gatedReady[3:0]), 32'h9);
    end
  endtask

  task automatic testDisable();
    partEn = 1'b0;
    entryReady = 8'b1011_0111;
    entryThread = 8'b0101_1010;
    for (int e = 0; e < NE; e++) entryRes[e] = 2'(e % 4);
    for (int i = 0; i < 6; i++) begin
      step(); #1;
      check(gatedReady == entryReady, "R7 bypass", 32'(gatedReady), 32'(entryReady));
    end
  endtask

  task automatic testNotReady();
    partEn = 1'b1;
    entryReady = '0;
    for (int i = 0; i < 4; i++) begin
      step();
      for (int e = 0; e < NE; e++) begin
        entryRes[e] = 2'(e % 4);
        entryThread[e] = expOwn(e % 4, cyc);
      end
      #1;
      check(gatedReady == '0, "R8 idle entries", 32'(gatedReady), 32'h0);
    end
  endtask

  task automatic testMixed();
    logic [15:0] lfsr = 16'hACE1;
    partEn = 1'b1;
    for (int i = 0; i < 40; i++) begin
      step();
      for (int e = 0; e < NE; e++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        entryReady[e]  = lfsr[0] | lfsr[5];
        entryThread[e] = lfsr[3];
        entryRes[e]    = lfsr[9:8];
      end
      #1;
      check(gatedReady == expGated(1'b1, cyc), "R4 mixed traffic", 32'(gatedReady), 32'(expGated(1'b1, cyc)));
    end
  endtask

  initial begin
    testReset();
    testSingleCycle();
    testPeriod();
    testGap();
    testSpatial();
    testDisable();
    testNotReady();
    testMixed();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule